// File: doc/BRIEF.md
# GPIO bank interrupt detector

This block watches the 32 input pins of one GPIO bank and turns pin activity into an interrupt request. Each pin passes through a two-flop synchronizer. A third register holds the previous synchronized sample, so a change between the two counts as an edge. Three per-pin type bits select one of five trigger modes: falling edge, rising edge, both edges, level low or level high. A pin whose trigger condition is met sets its bit in a sticky status register. Software clears status bits by writing ones to them. The enabled status bits are ORed into one interrupt line.

A small register port reads and writes the enable register, the three type registers and the status register. Each sits at a fixed byte offset, and the port uses no handshake. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high.

Detection is held off while the synchronizer pipeline still carries reset zeros. A two-state phase machine does this. It starts in WARM after reset. It counts one edge per cycle and takes the WARM→LIVE transition once the previous-sample register holds a real pin sample, which is the third clock edge after reset. LIVE is absorbing until the next reset, and events are recognised only in LIVE.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register byte offsets are: enable 0x00, type0 0x04, type1 0x08, type2 0x0C, status 0x10. Bit n of every register belongs to pin n. The first four registers read back what was last written. Any other offset reads zero and ignores writes.
- R2: With type1=0, type2=0 and type0=0, a high-to-low transition of the synchronized pin sets the pin's status bit.
- R3: With type1=0, type2=0 and type0=1, a low-to-high transition of the synchronized pin sets the pin's status bit.
- R4: With type1=0 and type2=1, either transition sets the pin's status bit, whatever the value of type0.
- R5: With type1=1 the pin is level sensitive. It is active high when type0=1 and active low when type0=0. The status bit sets on every cycle the level is active.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A trigger in the same cycle wins over the clear, so an active level holds its status bit at 1.
- R7: irq_o is high exactly when some pin has both its status bit and its enable bit at 1. Status bits latch regardless of enable.
- R8: A pin change driven just after clock edge k shows in status after edge k+3 and not before.
- R9: No status bit sets before the fourth clock edge after reset. This holds even when pins are high during reset and a rising mode is armed right after reset.
- R10: After reset every register reads zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pins_i | input | 32 | Asynchronous pin inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the false edge that reset zeros in the synchronizer would produce. Reaching it needs pins already high while reset is asserted, plus a rising mode written on the very first cycle after reset, before the previous-sample register holds a real value. The bench builds exactly that opening sequence. A second hard case is a clear written while a level trigger stays active. The bench drives level modes and issues all-ones clears while the level is held, which exercises the priority of set over clear. Further phases use random pin flips interleaved with random register writes, and each cycle's result is compared against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LVL_LO,
        TRIG_LVL_HI
    } trig_e;

    typedef enum logic {
        PH_WARM,
        PH_LIVE
    } phase_e;

    typedef enum logic [2:0] {
        SEL_EN,
        SEL_T0,
        SEL_T1,
        SEL_T2,
        SEL_STS,
        SEL_NONE
    } regsel_e;

    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_TYPE0  = 'h04;
    localparam int OFS_TYPE1  = 'h08;
    localparam int OFS_TYPE2  = 'h0C;
    localparam int OFS_STATUS = 'h10;

    // type1 selects level operation; otherwise type2 selects both edges.
    function automatic trig_e trig_decode(input logic t0, input logic t1, input logic t2);
        if (t1)
            return t0 ? TRIG_LVL_HI : TRIG_LVL_LO;
        else if (t2)
            return TRIG_BOTH;
        else if (t0)
            return TRIG_RISE;
        else
            return TRIG_FALL;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] pins_i,
    output logic [NPINS-1:0] smp_o,
    output logic [NPINS-1:0] prev_o,
    output logic             live_o
);
    localparam int CW = $clog2(SYNC_STAGES + 1);

    logic [NPINS-1:0] stg_q [SYNC_STAGES];
    logic [NPINS-1:0] prev_q;
    phase_e           phase_q, phase_d;
    logic [CW-1:0]    cnt_q, cnt_d;

    // Synchronizer chain plus the previous-sample register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= pins_i;
            for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
            prev_q <= stg_q[SYNC_STAGES-1];
        end
    end

    // Phase machine: state register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_WARM;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Phase machine: next state. WARM lasts until prev_q holds a real sample.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_WARM: begin
                if (cnt_q == CW'(SYNC_STAGES))
                    phase_d = PH_LIVE;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            PH_LIVE: phase_d = PH_LIVE;
            default: phase_d = PH_WARM;
        endcase
    end

    // Outputs.
    always_comb begin
        live_o = (phase_q == PH_LIVE);
        smp_o  = stg_q[SYNC_STAGES-1];
        prev_o = prev_q;
    end

    p_live_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        live_o |=> live_o);

    p_warm_sample_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(live_o) |-> (prev_q == $past(smp_o)));

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic live_i,
    input  logic smp_i,
    input  logic prev_i,
    input  logic t0_i,
    input  logic t1_i,
    input  logic t2_i,
    input  logic clr_i,
    output logic sts_o
);
    trig_e mode;
    logic  hit_raw;
    logic  hit;

    always_comb mode = trig_decode(t0_i, t1_i, t2_i);

    always_comb begin
        unique case (mode)
            TRIG_FALL:   hit_raw = prev_i & ~smp_i;
            TRIG_RISE:   hit_raw = ~prev_i & smp_i;
            TRIG_BOTH:   hit_raw = prev_i ^ smp_i;
            TRIG_LVL_LO: hit_raw = ~smp_i;
            TRIG_LVL_HI: hit_raw = smp_i;
            default:     hit_raw = 1'b0;
        endcase
        hit = live_i & hit_raw;
    end

    // A trigger outranks a clear in the same cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i)       sts_o <= 1'b0;
        else if (hit)    sts_o <= 1'b1;
        else if (clr_i)  sts_o <= 1'b0;
    end

    p_fall_set_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_i && !t1_i && !t2_i && !t0_i && prev_i && !smp_i) |=> sts_o);

    p_rise_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_i && !t1_i && !t2_i && t0_i && !prev_i && smp_i) |=> sts_o);

    p_level_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_i && t1_i && (t0_i == smp_i)) |=> sts_o);

    p_clear_only_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sts_o) |-> $past(clr_i));

    p_warm_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !live_i |=> !$rose(sts_o));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  wdata_i,
    input  logic [NPINS-1:0]  sts_i,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  t0_o,
    output logic [NPINS-1:0]  t1_o,
    output logic [NPINS-1:0]  t2_o,
    output logic [NPINS-1:0]  clr_o,
    output logic [NPINS-1:0]  rdata_o
);
    regsel_e          sel;
    logic [NPINS-1:0] en_q, t0_q, t1_q, t2_q;

    always_comb begin
        sel = SEL_NONE;
        if      (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_EN;
        else if (addr_i == ADDR_W'(OFS_TYPE0))  sel = SEL_T0;
        else if (addr_i == ADDR_W'(OFS_TYPE1))  sel = SEL_T1;
        else if (addr_i == ADDR_W'(OFS_TYPE2))  sel = SEL_T2;
        else if (addr_i == ADDR_W'(OFS_STATUS)) sel = SEL_STS;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= '0;
            t0_q <= '0;
            t1_q <= '0;
            t2_q <= '0;
        end else if (wr_en_i) begin
            unique case (sel)
                SEL_EN:            en_q <= wdata_i;
                SEL_T0:            t0_q <= wdata_i;
                SEL_T1:            t1_q <= wdata_i;
                SEL_T2:            t2_q <= wdata_i;
                SEL_STS, SEL_NONE: ;
                default:           ;
            endcase
        end
    end

    always_comb begin
        clr_o = (wr_en_i && sel == SEL_STS) ? wdata_i : '0;
        en_o  = en_q;
        t0_o  = t0_q;
        t1_o  = t1_q;
        t2_o  = t2_q;
        unique case (sel)
            SEL_EN:   rdata_o = en_q;
            SEL_T0:   rdata_o = t0_q;
            SEL_T1:   rdata_o = t1_q;
            SEL_T2:   rdata_o = t2_q;
            SEL_STS:  rdata_o = sts_i;
            SEL_NONE: rdata_o = '0;
            default:  rdata_o = '0;
        endcase
    end

    p_wr_type1_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && sel == SEL_T1) |=> (t1_q == $past(wdata_i)));

    p_wr_enable_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && sel == SEL_EN) |=> (en_q == $past(wdata_i)));

    p_reset_zero_r10: assert property (@(posedge clk_i)
        rst_i |=> (en_q == '0 && t0_q == '0 && t1_q == '0 && t2_q == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    output logic              irq_o
);
    logic [NPINS-1:0] smp, prev, sts, en, t0, t1, t2, clr;
    logic             live;

    gpio_irq_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pins_i (pins_i),
        .smp_o  (smp),
        .prev_o (prev),
        .live_o (live)
    );

    gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .sts_i   (sts),
        .en_o    (en),
        .t0_o    (t0),
        .t1_o    (t1),
        .t2_o    (t2),
        .clr_o   (clr),
        .rdata_o (rdata_o)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .live_i (live),
            .smp_i  (smp[p]),
            .prev_i (prev[p]),
            .t0_i   (t0[p]),
            .t1_i   (t1[p]),
            .t2_i   (t2[p]),
            .clr_i  (clr[p]),
            .sts_o  (sts[p])
        );
    end

    always_comb irq_o = |(sts & en);

    p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (en != '0));

    p_irq_needs_sts_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (sts != '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          wr = 1'b0;
    logic [4:0]    addr = 5'h10;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic          irq;

    always #4 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .pins_i  (pins),
        .wr_en_i (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    int    total = 0;
    int    bad = 0;
    string tag = "R10";
    bit    cmp_on = 1'b0;

    function automatic void check(string t, logic [NP-1:0] got, logic [NP-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", t, got, exp, $time);
        end
    endfunction

    // Behavioural reference model.
    logic [NP-1:0] m_en, m_t0, m_t1, m_t2, m_st;
    logic [NP-1:0] hist[$];
    int            nedge;

    always @(posedge clk) begin
        logic [NP-1:0] ev;
        logic [NP-1:0] clr;
        logic          cur, old;
        if (rst) begin
            m_en = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0; m_st = '0;
            hist = '{32'h0, 32'h0, 32'h0};
            nedge = 0;
        end else begin
            ev = '0;
            if (nedge >= 3) begin
                for (int i = 0; i < NP; i++) begin
                    cur = hist[1][i];
                    old = hist[2][i];
                    if (m_t1[i])      ev[i] = m_t0[i] ? cur : !cur;
                    else if (m_t2[i]) ev[i] = cur ^ old;
                    else if (m_t0[i]) ev[i] = cur & !old;
                    else              ev[i] = !cur & old;
                end
            end
            clr = (wr && addr == 5'h10) ? wdata : '0;
            m_st = (m_st & ~clr) | ev;
            if (wr) begin
                case (addr)
                    5'h00: m_en = wdata;
                    5'h04: m_t0 = wdata;
                    5'h08: m_t1 = wdata;
                    5'h0C: m_t2 = wdata;
                    default: ;
                endcase
            end
            hist.push_front(pins);
            void'(hist.pop_back());
            nedge++;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_st & m_en)});
            if (addr == 5'h10) check({tag, " status"}, rdata, m_st);
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [NP-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr = 1'b0; addr = 5'h10; wdata = '0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [NP-1:0] exp, input string t);
        addr = a;
        @(negedge clk);
        check(t, rdata, exp);
        @(posedge clk); #2;
        addr = 5'h10;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        pins = '1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        cmp_on = 1'b1;
        // R9: pins high through reset, rising mode armed at once.
        tag = "R9";
        wr_reg(5'h04, '1);
        idle(6);
        rd_reg(5'h10, '0, "R9 no false edge");
        // R10: reset values.
        tag = "R10";
        rd_reg(5'h00, '0, "R10 enable");
        rd_reg(5'h08, '0, "R10 type1");
        rd_reg(5'h0C, '0, "R10 type2");
        // R1: readback and decoding.
        tag = "R1";
        wr_reg(5'h00, 32'hA5A5_0F0F);
        wr_reg(5'h08, 32'h1234_5678);
        wr_reg(5'h0C, 32'h8000_0001);
        rd_reg(5'h00, 32'hA5A5_0F0F, "R1 enable");
        rd_reg(5'h04, 32'hFFFF_FFFF, "R1 type0");
        rd_reg(5'h08, 32'h1234_5678, "R1 type1");
        rd_reg(5'h0C, 32'h8000_0001, "R1 type2");
        wr_reg(5'h14, 32'hFFFF_FFFF);
        rd_reg(5'h14, '0, "R1 unmapped");
        rd_reg(5'h1C, '0, "R1 unmapped");
        wr_reg(5'h08, '0);
        wr_reg(5'h0C, '0);
        wr_reg(5'h00, '0);
        wr_reg(5'h10, '1);
        rd_reg(5'h10, '0, "R6 clear all");
        // R2: falling edges on every pin, masked.
        tag = "R2";
        wr_reg(5'h04, '0);
        pins = '0;
        idle(4);
        rd_reg(5'h10, '1, "R2 falling");
        tag = "R7";
        @(negedge clk); check("R7 masked irq", {31'h0, irq}, 32'h0);
        @(posedge clk); #2;
        wr_reg(5'h00, 32'h0000_0100);
        @(negedge clk); check("R7 enabled irq", {31'h0, irq}, 32'h1);
        @(posedge clk); #2;
        tag = "R6";
        wr_reg(5'h10, 32'h0000_FFFF);
        rd_reg(5'h10, 32'hFFFF_0000, "R6 partial clear");
        wr_reg(5'h10, 32'h0);
        rd_reg(5'h10, 32'hFFFF_0000, "R6 zero write");
        @(negedge clk); check("R7 irq after clear", {31'h0, irq}, 32'h0);
        @(posedge clk); #2;
        wr_reg(5'h10, '1);
        // R8: latency, rising on pins 0..7.
        tag = "R8";
        wr_reg(5'h04, 32'h0000_00FF);
        pins = 32'h0000_0008;
        @(posedge clk); @(posedge clk);
        @(negedge clk); check("R8 before edge k+3", {31'h0, rdata[3]}, 32'h0);
        @(negedge clk); check("R8 after edge k+3", {31'h0, rdata[3]}, 32'h1);
        @(posedge clk); #2;
        // R3 / R2 mixed modes.
        tag = "R3";
        pins = 32'h0000_0F0F;
        idle(4);
        rd_reg(5'h10, 32'h0000_000F, "R3 rising");
        tag = "R2";
        pins = '0;
        idle(4);
        rd_reg(5'h10, 32'h0000_0F0F, "R2 falling subset");
        wr_reg(5'h10, '1);
        // R4: both edges on pins 4..7.
        tag = "R4";
        wr_reg(5'h0C, 32'h0000_00F0);
        pins = 32'h0000_00F0;
        idle(4);
        rd_reg(5'h10, 32'h0000_00F0, "R4 rise");
        wr_reg(5'h10, '1);
        pins = '0;
        idle(4);
        rd_reg(5'h10, 32'h0000_00F0, "R4 fall");
        wr_reg(5'h10, '1);
        // R5: levels, pins 8..11 low-active, 12..15 high-active.
        tag = "R5";
        wr_reg(5'h0C, '0);
        wr_reg(5'h04, 32'h0000_F0FF);
        wr_reg(5'h08, 32'h0000_FF00);
        idle(2);
        rd_reg(5'h10, 32'h0000_0F00, "R5 level low");
        wr_reg(5'h10, '1);
        rd_reg(5'h10, 32'h0000_0F00, "R6 level wins clear");
        pins = 32'h0000_F000;
        idle(4);
        rd_reg(5'h10, 32'h0000_FF00, "R5 level high");
        pins = 32'h0000_0F00;
        idle(4);
        wr_reg(5'h10, '1);
        rd_reg(5'h10, '0, "R5 inactive level clears");
        // Random mix against the model.
        tag = "R7 random";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7) == 0) begin
                case ($urandom_range(4))
                    0: wr_reg(5'h00, $urandom);
                    1: wr_reg(5'h04, $urandom);
                    2: wr_reg(5'h08, $urandom & 32'h0F0F_0F0F);
                    3: wr_reg(5'h0C, $urandom);
                    default: wr_reg(5'h10, $urandom);
                endcase
            end else begin
                pins = pins ^ ($urandom & $urandom);
                idle(1);
            end
        end
        idle(4);
        cmp_on = 1'b0;
        summary();
        $finish;
    end

endmodule